// File: doc/BRIEF.md
# Host-Bridge Shadow Memory Router

This block sits in a host bridge and chooses, for each processor memory access, whether it is served by local DRAM or passed down to the expansion bus. It looks at a 32-bit physical address and a write flag, and it makes the choice combinationally from a small set of byte-wide configuration registers. Those registers are reached through a simple byte-addressed configuration port.

Below 1 MiB the routing follows firmware shadowing practice. The legacy window from 0xC0000 to 0xFFFFF is split into twelve 16 KiB segments plus one 64 KiB top segment. Each segment has its own read-enable bit and its own write-enable bit, so firmware can copy option ROM code into DRAM while reads still come from ROM, and can later flip to DRAM reads with writes locked out. Other controls are:
- a base-memory size mode, which can return 512–640K to the bus;
- a hole mode, which can open 15–16 MiB to the bus;
- a graphics/SMM window bit, which opens 0xA0000–0xBFFFF to DRAM.

Above 16 MiB, DRAM ends at the configured memory size.

Top module: `hb_shadow_router`

## Requirements
- R1: After reset the registers read back as follows: cache control (offset 0x52) 0xA2, DRAM control (0x57) 0x01, the seven attribute bytes (0x59–0x5F, byte i at 0x59+i) 0x00, the eight row-boundary bytes (0x60–0x67) 0x02, and SMM window control (0x72) 0x02.
- R2: A config write is accepted on a rising edge with cfg_wr high and takes effect from the next cycle. A config read with cfg_rd high returns the data on cfg_rdata one edge later. cfg_rdata holds its value while cfg_rd is low, and no register changes without a write.
- R3: Config offsets other than those in R1 read as 0x00, and writes to them change no register.
- R4: Exactly one of dram_sel and bus_sel is high at all times.
- R5: 0x00000–0x7FFFF always routes to DRAM. 0x80000–0x9FFFF routes to DRAM unless DRAM-control bits [7:6] equal 01, in which case it goes to the bus.
- R6: 0xA0000–0xBFFFF routes to DRAM only while SMM-control bit 6 is 1. Otherwise it goes to the bus.
- R7: Segment k (0..11) covers 0xC0000+k·0x4000 for 16 KiB and is controlled by attribute byte 1+k/2. An even k uses bit 0 for reads and bit 1 for writes; an odd k uses bit 4 for reads and bit 5 for writes. A set bit routes that direction to DRAM and a clear bit routes it to the bus. The other bits have no effect.
- R8: 0xF0000–0xFFFFF is controlled by attribute byte 0: bit 4 for reads and bit 5 for writes, with the same meaning as in R7. Bits 0 and 1 of byte 0 have no effect.
- R9: 0x100000–0xEFFFFF always routes to DRAM. 0xF00000–0xFFFFFF routes to DRAM unless DRAM-control bits [7:6] equal 10.
- R10: From 0x1000000 up to MEM_MB·1 MiB − 1 routes to DRAM. Every address at or above MEM_MB·1 MiB goes to the bus. MEM_MB must be a multiple-free integer count of MiB of at least 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_rd | input | 1 | Config read strobe |
| cfg_addr | input | 8 | Config byte offset |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Registered config read data |
| mem_addr | input | 32 | Physical address of the access |
| mem_write | input | 1 | 1 for a write access, 0 for a read |
| dram_sel | output | 1 | Access is served by local DRAM |
| bus_sel | output | 1 | Access is forwarded to the expansion bus |

## Verification
The bench sweeps both edges of every legacy segment in both directions under attribute patterns whose read and write bits disagree. A design that swapped the read and write bits, or mixed up lower and upper halves or adjacent bytes, would route a read and a write of the same segment the wrong way. The bench also sets the unused attribute bits, so a decoder that looked at them would misroute. Each DRAM-control mode and the SMM bit are combined with probes at 0x7FFFF/0x80000, 0x9FFFF, 0xEFFFFF/0xF00000 and the memory-size edge, where an off-by-one boundary or a wrong mode encoding would flip the outcome. Writes to unmapped offsets are followed by readback of both those offsets and their neighbours, which exposes a decoder that aliases them onto real registers.

// File: rtl/hb_route_pkg.sv
package hb_route_pkg;

    localparam int ATTR_CNT = 7;
    localparam int ROW_CNT  = 8;
    localparam int SLOT_CNT = 2 * ATTR_CNT;
    localparam int SLOT_IW  = $clog2(SLOT_CNT);

    // Config offsets
    localparam logic [7:0] OFF_CACHE = 8'h52;
    localparam logic [7:0] OFF_DCTL  = 8'h57;
    localparam logic [7:0] OFF_ATTR0 = 8'h59;
    localparam logic [7:0] OFF_ROW0  = 8'h60;
    localparam logic [7:0] OFF_SMM   = 8'h72;

    // Reset values
    localparam logic [7:0] RST_CACHE = 8'hA2;
    localparam logic [7:0] RST_DCTL  = 8'h01;
    localparam logic [7:0] RST_SMM   = 8'h02;
    localparam logic [7:0] RST_ROW   = 8'h02;
    localparam logic [7:0] RST_ATTR  = 8'h00;

    // DRAM-control [7:6] modes
    localparam logic [1:0] DMODE_SMALL_BASE = 2'b01;
    localparam logic [1:0] DMODE_HOLE       = 2'b10;

    // Half-byte slots: byte j supplies slots 2j (low) and 2j+1 (high).
    // Slot 1 is the 64 KiB top segment, slots 2..13 the 16 KiB segments.
    localparam int SLOT_TOP64 = 1;
    localparam int SLOT_SEG0  = 2;

    typedef struct packed {
        logic [1:0]          dmode;
        logic                smm_open;
        logic [SLOT_CNT-1:0] slot_rd;
        logic [SLOT_CNT-1:0] slot_wr;
    } route_cfg_t;

    typedef enum logic [2:0] {
        RG_LOW, RG_BASEHI, RG_SMM, RG_SEG, RG_TOP64, RG_EXT, RG_HOLE, RG_HIGH
    } region_e;

    function automatic region_e classify(input logic [31:0] a);
        if      (a < 32'h0008_0000) return RG_LOW;
        else if (a < 32'h000A_0000) return RG_BASEHI;
        else if (a < 32'h000C_0000) return RG_SMM;
        else if (a < 32'h000F_0000) return RG_SEG;
        else if (a < 32'h0010_0000) return RG_TOP64;
        else if (a < 32'h00F0_0000) return RG_EXT;
        else if (a < 32'h0100_0000) return RG_HOLE;
        else                        return RG_HIGH;
    endfunction

endpackage

// File: rtl/hb_cfg_file.sv
module hb_cfg_file
    import hb_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output route_cfg_t cfg
);

    logic [7:0] cache_q, dctl_q, smm_q;
    logic [7:0] attr_q [ATTR_CNT];
    logic [7:0] row_q  [ROW_CNT];
    logic [7:0] rd_val;
    logic       rd_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cache_q <= RST_CACHE;
            dctl_q  <= RST_DCTL;
            smm_q   <= RST_SMM;
            for (int i = 0; i < ATTR_CNT; i++) attr_q[i] <= RST_ATTR;
            for (int i = 0; i < ROW_CNT; i++)  row_q[i]  <= RST_ROW;
        end else if (wr) begin
            if (addr == OFF_CACHE) cache_q <= wdata;
            if (addr == OFF_DCTL)  dctl_q  <= wdata;
            if (addr == OFF_SMM)   smm_q   <= wdata;
            for (int i = 0; i < ATTR_CNT; i++)
                if (addr == OFF_ATTR0 + 8'(i)) attr_q[i] <= wdata;
            for (int i = 0; i < ROW_CNT; i++)
                if (addr == OFF_ROW0 + 8'(i)) row_q[i] <= wdata;
        end
    end

    always_comb begin
        rd_val = 8'h00;
        rd_hit = 1'b0;
        if (addr == OFF_CACHE) begin rd_val = cache_q; rd_hit = 1'b1; end
        if (addr == OFF_DCTL)  begin rd_val = dctl_q;  rd_hit = 1'b1; end
        if (addr == OFF_SMM)   begin rd_val = smm_q;   rd_hit = 1'b1; end
        for (int i = 0; i < ATTR_CNT; i++)
            if (addr == OFF_ATTR0 + 8'(i)) begin rd_val = attr_q[i]; rd_hit = 1'b1; end
        for (int i = 0; i < ROW_CNT; i++)
            if (addr == OFF_ROW0 + 8'(i)) begin rd_val = row_q[i]; rd_hit = 1'b1; end
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= 8'h00;
        else if (rd) rdata <= rd_val;
    end

    always_comb begin
        cfg.dmode    = dctl_q[7:6];
        cfg.smm_open = smm_q[6];
        for (int j = 0; j < ATTR_CNT; j++) begin
            cfg.slot_rd[2*j]   = attr_q[j][0];
            cfg.slot_wr[2*j]   = attr_q[j][1];
            cfg.slot_rd[2*j+1] = attr_q[j][4];
            cfg.slot_wr[2*j+1] = attr_q[j][5];
        end
    end

    // R2: routing state only moves on an accepted write
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cfg));

    // R2: read data holds between reads
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

    // R3: unmapped offsets read as zero
    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd && !rd_hit) |=> (rdata == 8'h00));

endmodule

// File: rtl/hb_addr_route.sv
module hb_addr_route
    import hb_route_pkg::*;
#(
    parameter int MEM_MB = 64
) (
    input  route_cfg_t  cfg,
    input  logic [31:0] addr,
    input  logic        wr,
    output logic        hit
);

    localparam logic [32:0] LIMIT = 33'(MEM_MB) << 20;

    region_e            rg;
    logic [SLOT_IW-1:0] seg_slot;

    assign rg       = classify(addr);
    assign seg_slot = SLOT_IW'(addr[17:14]) + SLOT_IW'(SLOT_SEG0);

    always_comb begin
        unique case (rg)
            RG_LOW:    hit = 1'b1;
            RG_BASEHI: hit = (cfg.dmode != DMODE_SMALL_BASE);
            RG_SMM:    hit = cfg.smm_open;
            RG_SEG:    hit = wr ? cfg.slot_wr[seg_slot] : cfg.slot_rd[seg_slot];
            RG_TOP64:  hit = wr ? cfg.slot_wr[SLOT_TOP64] : cfg.slot_rd[SLOT_TOP64];
            RG_EXT:    hit = 1'b1;
            RG_HOLE:   hit = (cfg.dmode != DMODE_HOLE);
            RG_HIGH:   hit = ({1'b0, addr} < LIMIT);
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/hb_shadow_router.sv
module hb_shadow_router
    import hb_route_pkg::*;
#(
    parameter int MEM_MB = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic        cfg_rd,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic [31:0] mem_addr,
    input  logic        mem_write,
    output logic        dram_sel,
    output logic        bus_sel
);

    localparam logic [32:0] LIMIT = 33'(MEM_MB) << 20;

    route_cfg_t cfg_w;
    logic       hit_w;

    hb_cfg_file u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .rd    (cfg_rd),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg_w)
    );

    hb_addr_route #(.MEM_MB(MEM_MB)) u_route (
        .cfg  (cfg_w),
        .addr (mem_addr),
        .wr   (mem_write),
        .hit  (hit_w)
    );

    assign dram_sel = hit_w;
    assign bus_sel  = !hit_w;

    // R5: lowest 512 KiB is always DRAM
    p_low_dram_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_addr < 32'h0008_0000) |-> dram_sel);

    // R6: closed SMM window forwards to the bus
    p_smm_closed_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_addr >= 32'h000A_0000 && mem_addr < 32'h000C_0000 && !cfg_w.smm_open)
        |-> bus_sel);

    // R9: extended memory below the hole is always DRAM
    p_ext_dram_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_addr >= 32'h0010_0000 && mem_addr < 32'h00F0_0000) |-> dram_sel);

    // R10: nothing at or above the memory size reaches DRAM
    p_beyond_bus_r10: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, mem_addr} >= LIMIT) |-> bus_sel);

endmodule

// File: tb/hb_shadow_router_bench.sv
module hb_shadow_router_bench;

    localparam int          MEM_MB  = 64;
    localparam logic [31:0] MEM_TOP = 32'(MEM_MB) << 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [7:0]  cfg_addr = 8'h00, cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [31:0] mem_addr = 32'h0;
    logic        mem_write = 1'b0;
    logic        dram_sel, bus_sel;

    always #4 clk = ~clk; // 125 MHz

    hb_shadow_router #(.MEM_MB(MEM_MB)) u_hb_shadow_router (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_addr(mem_addr), .mem_write(mem_write),
        .dram_sel(dram_sel), .bus_sel(bus_sel)
    );

    typedef struct {
        int          due;
        int          req;
        bit          is_cfg;
        logic [7:0]  exp;
        logic [31:0] a;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    // Spec model of the register file (R1 offsets and reset values)
    logic [7:0] m_cache = 8'hA2, m_dctl = 8'h01, m_smm = 8'h02;
    logic [7:0] m_attr [7] = '{default: 8'h00};
    logic [7:0] m_row  [8] = '{default: 8'h02};

    function automatic logic [7:0] model_read(input logic [7:0] off);
        if (off == 8'h52) return m_cache;
        if (off == 8'h57) return m_dctl;
        if (off == 8'h72) return m_smm;
        if (off >= 8'h59 && off <= 8'h5F) return m_attr[off - 8'h59];
        if (off >= 8'h60 && off <= 8'h67) return m_row[off - 8'h60];
        return 8'h00; // R3
    endfunction

    // Spec model of routing, R5..R10
    function automatic bit ref_dram(input logic [31:0] a, input bit w);
        int k;
        if (a < 32'h0008_0000) return 1'b1;
        if (a < 32'h000A_0000) return m_dctl[7:6] != 2'b01;
        if (a < 32'h000C_0000) return m_smm[6];
        if (a < 32'h000F_0000) begin
            k = int'((a - 32'h000C_0000) >> 14);
            return m_attr[1 + k/2][(k%2)*4 + int'(w)];
        end
        if (a < 32'h0010_0000) return m_attr[0][4 + int'(w)];
        if (a < 32'h00F0_0000) return 1'b1;
        if (a < 32'h0100_0000) return m_dctl[7:6] != 2'b10;
        return a < MEM_TOP;
    endfunction

    function automatic int req_of(input logic [31:0] a);
        if (a < 32'h000A_0000) return 5;
        if (a < 32'h000C_0000) return 6;
        if (a < 32'h000F_0000) return 7;
        if (a < 32'h0010_0000) return 8;
        if (a < 32'h0100_0000) return 9;
        return 10;
    endfunction

    task automatic push(input int req, input bit is_cfg, input logic [7:0] e,
                        input logic [31:0] a);
        exp_t it;
        it.due = cyc + 1;
        it.req = req;
        it.is_cfg = is_cfg;
        it.exp = e;
        it.a = a;
        sb.push_back(it);
    endtask

    task automatic cfg_write(input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_rd = 1'b0; cfg_addr = off; cfg_wdata = d;
        if (off == 8'h52) m_cache = d;
        if (off == 8'h57) m_dctl = d;
        if (off == 8'h72) m_smm = d;
        if (off >= 8'h59 && off <= 8'h5F) m_attr[off - 8'h59] = d;
        if (off >= 8'h60 && off <= 8'h67) m_row[off - 8'h60] = d;
    endtask

    task automatic cfg_read(input logic [7:0] off, input int req);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b1; cfg_addr = off;
        push(req, 1'b1, model_read(off), {24'h0, off});
    endtask

    task automatic probe(input logic [31:0] a, input bit w);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0; mem_addr = a; mem_write = w;
        push(req_of(a), 1'b0, {7'b0, ref_dram(a, w)}, a);
    endtask

    task automatic probe_both(input logic [31:0] a);
        probe(a, 1'b0);
        probe(a, 1'b1);
    endtask

    task automatic idle();
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0;
    endtask

    // Boundary sweep over every region and segment edge
    task automatic sweep();
        probe_both(32'h0000_0000); probe_both(32'h0007_FFFF);
        probe_both(32'h0008_0000); probe_both(32'h0009_FFFF);
        probe_both(32'h000A_0000); probe_both(32'h000B_FFFF);
        for (int k = 0; k < 12; k++) begin
            probe_both(32'h000C_0000 + 32'(k) * 32'h4000);
            probe_both(32'h000C_0000 + 32'(k) * 32'h4000 + 32'h3FFF);
        end
        probe_both(32'h000F_0000); probe_both(32'h000F_FFFF);
        probe_both(32'h0010_0000); probe_both(32'h00EF_FFFF);
        probe_both(32'h00F0_0000); probe_both(32'h00FF_FFFF);
        probe_both(32'h0100_0000); probe_both(MEM_TOP - 32'h1);
        probe_both(MEM_TOP);       probe_both(32'hFFFF_FFFF);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Monitor: pops expectations due this cycle and compares
    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            while (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_cfg) begin
                    checks++;
                    if (cfg_rdata !== e.exp) begin
                        fails++;
                        $display("FAIL R%0d cfg offset %h: actual %h expected %h",
                                 e.req, e.a[7:0], cfg_rdata, e.exp);
                    end
                end else begin
                    checks++;
                    if (dram_sel !== e.exp[0]) begin
                        fails++;
                        $display("FAIL R%0d addr %h wr %0b: dram_sel actual %b expected %b",
                                 e.req, e.a, mem_write, dram_sel, e.exp[0]);
                    end
                    checks++; // R4 one-hot pair
                    if (bus_sel !== ~e.exp[0] || (dram_sel ^ bus_sel) !== 1'b1) begin
                        fails++;
                        $display("FAIL R4 addr %h: bus_sel actual %b expected %b",
                                 e.a, bus_sel, ~e.exp[0]);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual hung run, expected completion");
            summary();
            $finish;
        end
    end

    localparam logic [7:0] PATS [4] = '{8'h11, 8'h22, 8'hDE, 8'hED};
    localparam logic [7:0] DCTLS [4] = '{8'h41, 8'h81, 8'hC1, 8'h01};
    localparam logic [7:0] SMMS [4] = '{8'h42, 8'h02, 8'h42, 8'hBF};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values at every mapped offset
        cfg_read(8'h52, 1);
        cfg_read(8'h57, 1);
        cfg_read(8'h72, 1);
        for (int i = 0; i < 7; i++) cfg_read(8'h59 + 8'(i), 1);
        for (int i = 0; i < 8; i++) cfg_read(8'h60 + 8'(i), 1);

        // R3: unmapped offsets read zero and ignore writes
        cfg_read(8'h00, 3); cfg_read(8'h50, 3); cfg_read(8'h58, 3);
        cfg_read(8'h68, 3); cfg_read(8'h71, 3); cfg_read(8'hFF, 3);
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h71, 8'hFF);
        cfg_write(8'h68, 8'hFF);
        cfg_read(8'h58, 3); cfg_read(8'h71, 3); cfg_read(8'h68, 3);
        cfg_read(8'h57, 3); cfg_read(8'h72, 3); cfg_read(8'h5F, 3); cfg_read(8'h67, 3);

        // R2: write takes effect on the next cycle; readback straight after
        cfg_write(8'h52, 8'h3C);
        cfg_read(8'h52, 2);
        cfg_write(8'h63, 8'h9A);
        cfg_read(8'h63, 2);
        cfg_read(8'h62, 2);
        idle(); idle();
        // R2: read data holds while no read is issued (expect the 0x62 value)
        @(negedge clk);
        cfg_rd = 1'b0;
        push(2, 1'b1, model_read(8'h62), 32'h62);

        // R2 / R7: a segment write is visible to the very next access
        cfg_write(8'h59 + 8'd1, 8'h01);
        probe(32'h000C_0000, 1'b0);
        probe(32'h000C_0000, 1'b1);

        // R5..R10 at reset-like state for the shadow area
        cfg_write(8'h5A, 8'h00);
        sweep();

        // R7, R8: independent read/write enables, unused bits set
        for (int p = 0; p < 4; p++) begin
            for (int j = 0; j < 7; j++)
                cfg_write(8'h59 + 8'(j), PATS[(j + p) % 4]);
            cfg_write(8'h57, DCTLS[p]);   // R5, R9 modes
            cfg_write(8'h72, SMMS[p]);    // R6
            sweep();
            for (int j = 0; j < 7; j++) cfg_read(8'h59 + 8'(j), 2);
        end

        // R8: only bits 4/5 of byte 0 matter
        cfg_write(8'h59, 8'h03);
        probe_both(32'h000F_8000);
        cfg_write(8'h59, 8'h30);
        probe_both(32'h000F_8000);

        repeat (4) idle();
        if (sb.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R2 pending expectations: actual %0d expected 0", sb.size());
        end
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

endmodule